// File: doc/BRIEF.md
# Match-Based Watchdog Timer

This block is a memory-mapped watchdog. An up-counter advances once per reference tick. The tick arrives as a one-cycle enable in the main clock domain. The counter value is compared with a programmable match value. When the two are equal while counting, the match unit can do any of the following, as software selects: flag an interrupt, clear and halt the counter, drive an external match pin, and start a reset pulse. The reset pulse goes on an internal reset line, an external reset line, or both, and its length is programmable in ticks. Software can also hold either reset line active directly. A debug-halt input can freeze the counter when software asks for it.

A sticky reset-cause flag records that the watchdog drove a reset. This flag is reset only by the power-on reset input. It therefore survives the system reset that the watchdog itself produces, and boot software can read it afterwards. All other state is cleared by the system reset input.

The register port is single-cycle. A write takes effect at the clock edge where `bus_sel` and `bus_we` are high. Read data is combinational from the address. Only word-aligned addresses are decoded. The word index is address bits 4:2, in this order: 0 interrupt status, 1 control, 2 counter, 3 match control, 4 match value, 5 match output, 6 pulse length, 7 reset cause.

Top module: `wdt_match_top`

## Requirements
- R1: After reset every register reads 0, except pulse length, which reads 0xFFFF. Reserved bits always read 0. Control uses bits 0 (run), 1 (clear request) and 2 (freeze on debug halt). Match control uses bits 0 (interrupt), 2 (stop), 3 (internal reset), 4 (external reset), 5 (force internal) and 6 (force external). The match-output register uses bit 0 (level) and bits 5:4 (action). Pulse length uses bits 15:0.
- R2: When run is set and no clear is pending, the counter increments by one on each tick. It holds when run is clear or when tick is low.
- R3: Writing control bit 1 sets a pending clear, and control bit 1 reads 1 while the clear is pending. On the next tick the counter becomes 0 and the pending bit reads 0 again.
- R4: While control bit 2 is set and `dbg_halt` is high, the counter does not advance on ticks.
- R5: A match is a tick while counting with counter equal to the match value. A match sets interrupt-status bit 0. Writing 1 to that bit clears it; writing 0 leaves it set. `irq` equals status bit 0 AND match-control bit 0.
- R6: A match with match-control bit 2 set loads the counter with 0 and clears control bit 0.
- R7: A match with match-control bit 3 (or bit 4) set drives `int_rst` (or `ext_rst`) high from the next cycle for L ticks, where L is the pulse length. A length of 0 gives a one-tick pulse.
- R8: Match-control bits 5 and 6 hold `int_rst` and `ext_rst` high respectively, from the cycle after the write, whatever the counter value.
- R9: `match_out` equals match-output bit 0, which software can write. On a match, the action in bits 5:4 updates it: 0 leaves it, 1 drives it low, 2 drives it high, 3 toggles it.
- R10: The reset-cause register, bit 0, becomes 1 the cycle after `int_rst` or `ext_rst` is high. It keeps that value through `rst_n` and is cleared only by `por_n`.
- R11: Writes to the counter register and to the reset-cause register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low system reset for all state except the cause flag |
| por_n | input | 1 | Active-low power-on reset for the cause flag |
| tick_en | input | 1 | One-cycle reference tick enable |
| dbg_halt | input | 1 | Debugger halt indication |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not selected |
| irq | output | 1 | Match interrupt |
| match_out | output | 1 | External match pin level |
| int_rst | output | 1 | Internal reset request |
| ext_rst | output | 1 | External reset output |

## Verification
Register effects are visible on `bus_rdata` after the write edge, and a match is decided at the tick edge. Status, `irq`, the match pin, the counter and the start of a reset pulse are therefore all due one cycle after the stimulus. The cause flag follows one cycle after a reset line rises. Inputs change on falling edges, and each task returns on a falling edge. Outputs are read there, and read data is taken shortly after the address is applied. Ticks are issued only by a task that raises `tick_en` for an exact number of rising edges, so the expected counter and pulse values are exact tick counts.

// File: rtl/wdt_match_pkg.sv
package wdt_match_pkg;
   typedef enum logic [2:0] {
      WI_ISR  = 3'd0,
      WI_CTL  = 3'd1,
      WI_CNT  = 3'd2,
      WI_MCTL = 3'd3,
      WI_MVAL = 3'd4,
      WI_EMR  = 3'd5,
      WI_PLEN = 3'd6,
      WI_RSTS = 3'd7
   } wreg_e;

   localparam int unsigned MC_IRQ  = 0;
   localparam int unsigned MC_STOP = 2;
   localparam int unsigned MC_IRST = 3;
   localparam int unsigned MC_XRST = 4;
   localparam int unsigned MC_FIRST = 5;
   localparam int unsigned MC_FXRST = 6;
   localparam logic [6:0] MC_MASK = 7'b111_1101;

   typedef enum logic [1:0] {
      EM_KEEP   = 2'd0,
      EM_LOW    = 2'd1,
      EM_HIGH   = 2'd2,
      EM_TOGGLE = 2'd3
   } emact_e;
endpackage

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             clr_pend,
   input  logic             stop_on_hit,
   input  logic [CNT_W-1:0] match_val,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic active;

   assign active = tick && run && !clr_pend;
   assign hit    = active && (cnt == match_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (tick && clr_pend)   cnt <= '0;
      else if (hit && stop_on_hit) cnt <= '0;
      else if (active)             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int unsigned PULSE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               trig,
   input  logic               force_on,
   input  logic [PULSE_W-1:0] len,
   output logic               rst_out
);
   logic [PULSE_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     left <= '0;
      else if (trig)                  left <= (len == '0) ? PULSE_W'(1) : len;
      else if (tick && left != '0)    left <= left - 1'b1;
   end

   assign rst_out = force_on || (left != '0);
endmodule

// File: rtl/wdt_match_top.sv
module wdt_match_top #(
   parameter int unsigned CNT_W         = 32,
   parameter int unsigned PULSE_W       = 16,
   parameter bit          DBG_FREEZE_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        por_n,
   input  logic        tick_en,
   input  logic        dbg_halt,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [4:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   output logic        match_out,
   output logic        int_rst,
   output logic        ext_rst
);
   import wdt_match_pkg::*;

   localparam int unsigned DW    = 32;
   localparam int unsigned NRST  = 2;

   generate
      if (CNT_W < 2 || CNT_W > DW) begin : g_bad_cnt
         $error("wdt_match_top: CNT_W out of range");
      end
      if (PULSE_W < 1 || PULSE_W > DW) begin : g_bad_pulse
         $error("wdt_match_top: PULSE_W out of range");
      end
   endgenerate

   logic               acc_ok, wsel;
   wreg_e              widx;
   logic               run_q, clr_pend, frz;
   logic               isr_q, cause_q, lvl_q;
   emact_e             act_q;
   logic [6:0]         mctl_q;
   logic [CNT_W-1:0]   mval_q, cnt;
   logic [PULSE_W-1:0] plen_q;
   logic               hit, frozen, run_eff;
   logic [NRST-1:0]    trig_v, frc_v, rst_v;
   logic [DW-1:0]      rmux;

   assign acc_ok = bus_sel && (bus_addr[1:0] == 2'b00);
   assign wsel   = acc_ok && bus_we;
   assign widx   = wreg_e'(bus_addr[4:2]);

   generate
      if (DBG_FREEZE_EN) begin : g_frz
         assign frozen = frz && dbg_halt;
      end else begin : g_nofrz
         assign frozen = 1'b0;
      end
   endgenerate

   assign run_eff = run_q && !frozen;

   wdt_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .run(run_eff),
      .clr_pend(clr_pend), .stop_on_hit(mctl_q[MC_STOP]),
      .match_val(mval_q), .cnt(cnt), .hit(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0; clr_pend <= 1'b0; frz <= 1'b0;
      end else if (wsel && widx == WI_CTL) begin
         run_q    <= bus_wdata[0];
         clr_pend <= bus_wdata[1];
         frz      <= bus_wdata[2] && DBG_FREEZE_EN;
      end else begin
         if (hit && mctl_q[MC_STOP]) run_q <= 1'b0;
         if (tick_en && clr_pend)    clr_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q  <= 1'b0;
         mctl_q <= '0;
         mval_q <= '0;
         plen_q <= '1;
      end else begin
         if (hit)                                         isr_q <= 1'b1;
         else if (wsel && widx == WI_ISR && bus_wdata[0]) isr_q <= 1'b0;
         if (wsel && widx == WI_MCTL) mctl_q <= bus_wdata[6:0] & MC_MASK;
         if (wsel && widx == WI_MVAL) mval_q <= bus_wdata[CNT_W-1:0];
         if (wsel && widx == WI_PLEN) plen_q <= bus_wdata[PULSE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         act_q <= EM_KEEP;
      end else if (wsel && widx == WI_EMR) begin
         lvl_q <= bus_wdata[0];
         act_q <= emact_e'(bus_wdata[5:4]);
      end else if (hit) begin
         case (act_q)
            EM_LOW:    lvl_q <= 1'b0;
            EM_HIGH:   lvl_q <= 1'b1;
            EM_TOGGLE: lvl_q <= !lvl_q;
            default:   lvl_q <= lvl_q;
         endcase
      end
   end

   assign trig_v = {hit && mctl_q[MC_XRST], hit && mctl_q[MC_IRST]};
   assign frc_v  = {mctl_q[MC_FXRST], mctl_q[MC_FIRST]};

   generate
      for (genvar g = 0; g < NRST; g++) begin : g_rst
         wdt_pulse #(.PULSE_W(PULSE_W)) u_pulse (
            .clk(clk), .rst_n(rst_n), .tick(tick_en), .trig(trig_v[g]),
            .force_on(frc_v[g]), .len(plen_q), .rst_out(rst_v[g])
         );
      end
   endgenerate

   assign int_rst = rst_v[0];
   assign ext_rst = rst_v[1];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                 cause_q <= 1'b0;
      else if (int_rst || ext_rst) cause_q <= 1'b1;
   end

   always_comb begin
      rmux = '0;
      case (widx)
         WI_ISR:  rmux[0]          = isr_q;
         WI_CTL:  rmux[2:0]        = {frz, clr_pend, run_q};
         WI_CNT:  rmux[CNT_W-1:0]  = cnt;
         WI_MCTL: rmux[6:0]        = mctl_q;
         WI_MVAL: rmux[CNT_W-1:0]  = mval_q;
         WI_EMR:  rmux[5:0]        = {act_q, 3'b000, lvl_q};
         WI_PLEN: rmux[PULSE_W-1:0] = plen_q;
         WI_RSTS: rmux[0]          = cause_q;
         default: rmux             = '0;
      endcase
   end

   assign bus_rdata = acc_ok ? rmux : '0;
   assign irq       = isr_q && mctl_q[MC_IRQ];
   assign match_out = lvl_q;
endmodule

// File: rtl/wdt_match_chk.sv
module wdt_match_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             por_n,
   input logic             tick_en,
   input logic             dbg_halt,
   input logic             bus_sel,
   input logic             bus_we,
   input logic [4:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic             irq,
   input logic             int_rst,
   input logic             ext_rst,
   input logic             hit,
   input logic [CNT_W-1:0] cnt,
   input logic             clr_pend,
   input logic             frz,
   input logic [6:0]       mctl_q,
   input logic             cause_q
);
   logic wr_isr1, wr_fint, wr_fext;

   assign wr_isr1 = bus_sel && bus_we && bus_addr == 5'h00 && bus_wdata[0];
   assign wr_fint = bus_sel && bus_we && bus_addr == 5'h0C && bus_wdata[5];
   assign wr_fext = bus_sel && bus_we && bus_addr == 5'h0C && bus_wdata[6];

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pend && tick_en) |=> (cnt == '0)); // R3
   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && dbg_halt && !clr_pend) |=> $stable(cnt)); // R4
   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_isr1 && !hit) |=> !irq); // R5
   AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mctl_q[2]) |=> (cnt == '0)); // R6
   AST_TRIG_INT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mctl_q[3]) |=> int_rst); // R7
   AST_TRIG_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mctl_q[4]) |=> ext_rst); // R7
   AST_FORCE_INT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fint |=> int_rst); // R8
   AST_FORCE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fext |=> ext_rst); // R8
   AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!por_n)
      (int_rst || ext_rst) |=> cause_q); // R10
   AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!por_n)
      cause_q |=> cause_q); // R10
endmodule

bind wdt_match_top wdt_match_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_en(tick_en),
   .dbg_halt(dbg_halt), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
   .int_rst(int_rst), .ext_rst(ext_rst), .hit(hit), .cnt(cnt),
   .clr_pend(clr_pend), .frz(frz), .mctl_q(mctl_q), .cause_q(cause_q)
);

// File: tb/wdt_match_tb.sv
module wdt_match_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, match_out, int_rst, ext_rst;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [4:0] A_ISR = 5'h00, A_CTL = 5'h04, A_CNT = 5'h08,
      A_MCTL = 5'h0C, A_MVAL = 5'h10, A_EMR = 5'h14, A_PLEN = 5'h18,
      A_RSTS = 5'h1C;

   typedef struct packed {
      logic [4:0]  a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VTAB [NV] = '{
      '{5'h10, 32'h1234_5678, 32'h1234_5678},
      '{5'h10, 32'h0000_0000, 32'h0000_0000},
      '{5'h0C, 32'h0000_001D, 32'h0000_001D},
      '{5'h0C, 32'h0000_0082, 32'h0000_0000},
      '{5'h14, 32'h0000_03FE, 32'h0000_0030},
      '{5'h14, 32'h0000_0000, 32'h0000_0000},
      '{5'h18, 32'h0001_2345, 32'h0000_2345},
      '{5'h18, 32'h0000_FFFF, 32'h0000_FFFF},
      '{5'h04, 32'h0000_00F8, 32'h0000_0000},
      '{5'h08, 32'h0000_ABCD, 32'h0000_0000},
      '{5'h1C, 32'h0000_0001, 32'h0000_0000},
      '{5'h00, 32'h0000_00FE, 32'h0000_0000}
   };

   always #10 clk = ~clk;

   wdt_match_top dut_i (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_en(tick_en),
      .dbg_halt(dbg_halt), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .match_out(match_out), .int_rst(int_rst), .ext_rst(ext_rst)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic restart0();
      wr(A_CTL, 32'h2);
      ticks(1);
      wr(A_CTL, 32'h1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; por_n = 1'b1;

      // R1 reset state
      rdchk("R1 ctl", A_CTL, 32'h0);
      rdchk("R1 cnt", A_CNT, 32'h0);
      rdchk("R1 plen", A_PLEN, 32'hFFFF);
      rdchk("R1 rsts", A_RSTS, 32'h0);
      chk("R1 outs", {28'h0, irq, match_out, int_rst, ext_rst}, 32'h0);

      // R1 / R11 register vector table
      for (int i = 0; i < NV; i++) begin
         wr(VTAB[i].a, VTAB[i].d);
         rdchk((i == 9 || i == 10) ? "R11 ignored write" : "R1 readback", VTAB[i].a, VTAB[i].e);
      end

      // R2 counting
      wr(A_CTL, 32'h1);
      ticks(5);
      rdchk("R2 five ticks", A_CNT, 32'd5);
      repeat (3) @(negedge clk);
      rdchk("R2 no tick hold", A_CNT, 32'd5);
      wr(A_CTL, 32'h0);
      ticks(3);
      rdchk("R2 run clear hold", A_CNT, 32'd5);

      // R3 clear request
      wr(A_CTL, 32'h2);
      rdchk("R3 pending reads 1", A_CTL, 32'h2);
      rdchk("R3 not yet cleared", A_CNT, 32'd5);
      ticks(1);
      rdchk("R3 cleared", A_CNT, 32'd0);
      rdchk("R3 pending done", A_CTL, 32'h0);

      // R4 debug freeze
      dbg_halt = 1'b1;
      wr(A_CTL, 32'h5);
      ticks(4);
      rdchk("R4 frozen", A_CNT, 32'd0);
      dbg_halt = 1'b0;
      ticks(2);
      rdchk("R4 resumed", A_CNT, 32'd2);
      wr(A_CTL, 32'h1);
      dbg_halt = 1'b1;
      ticks(3);
      rdchk("R4 freeze bit off", A_CNT, 32'd5);
      dbg_halt = 1'b0;

      // R5 match flag and irq
      wr(A_ISR, 32'h1);
      rdchk("R5 flag cleared", A_ISR, 32'h0);
      wr(A_MVAL, 32'd7);
      wr(A_MCTL, 32'h1);
      ticks(2);
      chk("R5 no early irq", {31'h0, irq}, 32'h0);
      ticks(1);
      chk("R5 irq on match", {31'h0, irq}, 32'h1);
      rdchk("R5 flag set", A_ISR, 32'h1);
      wr(A_ISR, 32'h0);
      rdchk("R5 write0 keeps", A_ISR, 32'h1);
      wr(A_ISR, 32'h1);
      chk("R5 irq cleared", {31'h0, irq}, 32'h0);
      wr(A_MCTL, 32'h0);
      wr(A_MVAL, 32'd8);
      ticks(1);
      rdchk("R5 flag unmasked", A_ISR, 32'h1);
      chk("R5 irq masked", {31'h0, irq}, 32'h0);
      wr(A_ISR, 32'h1);

      // R6 + R7 stop and internal pulse
      wr(A_CTL, 32'h2);
      ticks(1);
      wr(A_PLEN, 32'd3);
      wr(A_MVAL, 32'd4);
      wr(A_MCTL, 32'h0C);
      wr(A_CTL, 32'h1);
      ticks(5);
      chk("R7 int pulse start", {30'h0, int_rst, ext_rst}, 32'h2);
      rdchk("R6 run cleared", A_CTL, 32'h0);
      rdchk("R6 counter zero", A_CNT, 32'h0);
      ticks(2);
      chk("R7 int pulse held", {31'h0, int_rst}, 32'h1);
      ticks(1);
      chk("R7 int pulse end", {31'h0, int_rst}, 32'h0);
      rdchk("R6 still stopped", A_CNT, 32'h0);
      rdchk("R10 cause set", A_RSTS, 32'h1);

      // R7 zero length gives one tick on external line
      wr(A_PLEN, 32'd0);
      wr(A_MCTL, 32'h10);
      wr(A_MVAL, 32'd0);
      wr(A_CTL, 32'h1);
      ticks(1);
      chk("R7 ext pulse", {30'h0, int_rst, ext_rst}, 32'h1);
      ticks(1);
      chk("R7 ext one tick", {31'h0, ext_rst}, 32'h0);

      // R8 force bits
      wr(A_MCTL, 32'h20);
      chk("R8 force int", {30'h0, int_rst, ext_rst}, 32'h2);
      wr(A_MCTL, 32'h40);
      chk("R8 force ext", {30'h0, int_rst, ext_rst}, 32'h1);
      wr(A_MCTL, 32'h0);
      chk("R8 release", {30'h0, int_rst, ext_rst}, 32'h0);

      // R9 match output
      wr(A_MVAL, 32'd0);
      wr(A_EMR, 32'h01);
      chk("R9 sw set", {31'h0, match_out}, 32'h1);
      wr(A_EMR, 32'h00);
      chk("R9 sw clear", {31'h0, match_out}, 32'h0);
      wr(A_EMR, 32'h20);
      restart0();
      ticks(1);
      chk("R9 action high", {31'h0, match_out}, 32'h1);
      rdchk("R9 emr readback", A_EMR, 32'h21);
      wr(A_EMR, 32'h11);
      restart0();
      ticks(1);
      chk("R9 action low", {31'h0, match_out}, 32'h0);
      wr(A_EMR, 32'h30);
      restart0();
      ticks(1);
      chk("R9 toggle up", {31'h0, match_out}, 32'h1);
      restart0();
      ticks(1);
      chk("R9 toggle down", {31'h0, match_out}, 32'h0);
      wr(A_EMR, 32'h01);
      restart0();
      ticks(1);
      chk("R9 action keep", {31'h0, match_out}, 32'h1);

      // R10 cause survives system reset, cleared by power-on
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rdchk("R10 survives rst_n", A_RSTS, 32'h1);
      rdchk("R10 ctl reset", A_CTL, 32'h0);
      @(negedge clk) begin rst_n = 1'b0; por_n = 1'b0; end
      repeat (2) @(negedge clk);
      rst_n = 1'b1; por_n = 1'b1;
      rdchk("R10 por clears", A_RSTS, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule